// File: doc/BRIEF.md
# I2C Start/Stop Condition Controller

This block decides when an I2C interface that can act as master or slave puts a START, a repeated START or a STOP on the bus, and it drives those edges through open-drain pull-down enables. Software writes two request bits: one asks for a START and one asks for a STOP. A third input enables the whole interface. The block keeps its own view of whether the bus is busy by watching the synchronised SDA and SCL lines for START and STOP conditions. It reports, with one-cycle pulses, when it takes or gives up mastership.

If a START is asked for while another master owns the bus, the block waits for that master's STOP. It then waits half a serial clock period and issues its own START. A START request made while the block is already master becomes a repeated START once a byte has gone across. A STOP request made as master drives a STOP and clears the request bit when that STOP is seen on the bus. A STOP request made while not master is a silent error recovery: nothing is driven, the bus is treated as freed, and the slave side is told to return to the not-addressed state. Byte shifting, acknowledge and address matching are outside the block; a byte-transferred pulse stands in for them.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: While `en` is 0, neither line is pulled low, mastership is not held, and written request bits stay as written with no action taken.
- R2: With `en`=1, the bus free and `sta_bit`=1, the block pulls SDA low while SCL is released. It then becomes master, emits a one-cycle `mst_gain` pulse and clears `sta_bit`. With `sta_bit`=0 no START is produced.
- R3: With `sta_bit`=1 and the bus busy, no line is pulled until a STOP is seen on the bus. SDA is then pulled low between HALF+2 and HALF+4 clock edges after the releasing SDA edge (half period plus synchroniser latency).
- R4: During a START, SDA stays pulled with SCL released for exactly HALF clock cycles before SCL is pulled low.
- R5: As master, a START request has no effect until `byte_done` has pulsed since the last START. After that, a repeated START is produced: SDA falls while SCL is high, mastership is kept, no new `mst_gain` pulse is emitted and `sta_bit` clears.
- R6: As master, `sto_bit`=1 drives a STOP. SCL is released first, and SDA is released exactly HALF cycles later. Once the STOP is seen on the bus, `sto_bit` clears, mastership ends and `mst_loss` pulses once.
- R7: With `sto_bit`=1 while not master, no line is pulled. `sto_bit` clears, `bus_busy` drops even if the bus is still held, and `slave_rst` pulses once.
- R8: When STA and STO are both set while master, the STOP is produced first and a fresh START follows, leaving the block master.
- R9: `bus_busy` rises on SDA falling while SCL is high and falls on SDA rising while SCL is high. SDA changes while SCL is low leave it unchanged.
- R10: In reset, both pull enables are 1 (released), and `is_master`, `bus_busy`, `sta_bit` and `sto_bit` are 0.
- R11: Dropping `en` while master releases both lines and ends mastership with a `mst_loss` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Interface enable |
| sw_wr | input | 1 | Write strobe for the request bits |
| sw_sta | input | 1 | START request value written on `sw_wr` |
| sw_sto | input | 1 | STOP request value written on `sw_wr` |
| byte_done | input | 1 | Pulse: one byte transferred as master |
| sda_i | input | 1 | SDA line level |
| scl_i | input | 1 | SCL line level |
| sda_pull_n | output | 1 | Active-low SDA pull-down enable |
| scl_pull_n | output | 1 | Active-low SCL pull-down enable |
| sta_bit | output | 1 | Current START request bit |
| sto_bit | output | 1 | Current STOP request bit |
| is_master | output | 1 | Block holds mastership |
| bus_busy | output | 1 | Bus seen as busy |
| mst_gain | output | 1 | One-cycle pulse on taking mastership |
| mst_loss | output | 1 | One-cycle pulse on leaving mastership |
| slave_rst | output | 1 | One-cycle pulse: return to not-addressed slave |

## Verification
A request bit is visible one edge after its write. A START from the idle state pulls SDA one edge later, and SCL follows exactly HALF edges after that. A STOP on the lines reaches `bus_busy` and the state machine three edges later: two synchroniser flops plus the edge-compare register. Timed intervals are measured by counting falling edges between the two observed output changes and compared with the exact value. Results that depend on line latency are awaited with bounded loops and then checked against a window, or a few cycles after they are due. All sampling and driving happens on the falling clock edge.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,   // nothing owned, lines released
    ST_WAIT,   // START pending, bus owned by someone else
    ST_GAP,    // half period after bus freed
    ST_SHOLD,  // SDA low, SCL high: START being held
    ST_MST,    // master between operations, SCL held low
    ST_PA,     // stop: SDA low with SCL low
    ST_PB,     // stop: SCL released, SDA low
    ST_PC,     // stop: SDA released, waiting to see STOP
    ST_RA,     // repeated start: SDA released, SCL low
    ST_RB      // repeated start: both released
  } cond_st_t;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_i,
  input  logic scl_i,
  input  logic force_free,
  output logic stop_det,
  output logic bus_busy
);
  logic [STAGES-1:0] sda_sh, scl_sh;
  logic sda_s, scl_s, sda_p, scl_p;
  logic start_det, busy_d, busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_sh <= '1;
      scl_sh <= '1;
      sda_p  <= 1'b1;
      scl_p  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_p  <= sda_s;
      scl_p  <= scl_s;
      busy_q <= busy_d;
    end
  end

  assign sda_s     = sda_sh[STAGES-1];
  assign scl_s     = scl_sh[STAGES-1];
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  always_comb begin
    busy_d = busy_q;
    if (force_free || stop_det) busy_d = 1'b0;
    else if (start_det)         busy_d = 1'b1;
  end

  assign bus_busy = busy_q;
endmodule

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
  parameter int HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int W = $clog2(HALF + 1);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)             cnt_d = W'(HALF);
    else if (cnt_q != '0) cnt_d = cnt_q - W'(1);
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == W'(1));
endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
  import i2c_cond_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sta,
  input  logic sto,
  input  logic bus_busy,
  input  logic stop_det,
  input  logic byte_done,
  input  logic tmr_done,
  output logic tmr_load,
  output logic sta_clr,
  output logic sto_clr,
  output logic force_free,
  output logic sda_pull_n,
  output logic scl_pull_n,
  output logic is_master,
  output logic mst_gain,
  output logic mst_loss,
  output logic slave_rst
);
  cond_st_t st_q, st_d;
  logic m_q, m_d, xfer_q, xfer_d;
  logic gain_q, loss_q, srst_q, srst_d;

  always_comb begin
    st_d = st_q; m_d = m_q; xfer_d = xfer_q;
    sta_clr = 1'b0; sto_clr = 1'b0; force_free = 1'b0; srst_d = 1'b0;
    if (!en) begin
      st_d = ST_IDLE; m_d = 1'b0; xfer_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (sto) begin
            sto_clr = 1'b1; force_free = 1'b1; srst_d = 1'b1;
          end
          if (sta) st_d = sto ? ST_GAP : (bus_busy ? ST_WAIT : ST_SHOLD);
        end
        ST_WAIT: begin
          if (sto) begin
            sto_clr = 1'b1; force_free = 1'b1; srst_d = 1'b1;
            st_d = ST_GAP;
          end else if (!sta)   st_d = ST_IDLE;
          else if (stop_det)   st_d = ST_GAP;
        end
        ST_GAP: begin
          if (!sta)          st_d = ST_IDLE;
          else if (tmr_done) st_d = ST_SHOLD;
        end
        ST_SHOLD: if (tmr_done) begin
          st_d = ST_MST; m_d = 1'b1; sta_clr = 1'b1; xfer_d = 1'b0;
        end
        ST_MST: begin
          if (byte_done) xfer_d = 1'b1;
          if (sto)                 st_d = ST_PA;
          else if (sta && xfer_q)  st_d = ST_RA;
        end
        ST_PA: if (tmr_done) st_d = ST_PB;
        ST_PB: if (tmr_done) st_d = ST_PC;
        ST_PC: if (stop_det) begin
          st_d = ST_IDLE; m_d = 1'b0; sto_clr = 1'b1; xfer_d = 1'b0;
        end
        ST_RA: if (tmr_done) st_d = ST_RB;
        ST_RB: if (tmr_done) st_d = ST_SHOLD;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign tmr_load = (st_d != st_q) &&
                    (st_d inside {ST_GAP, ST_SHOLD, ST_PA, ST_PB, ST_RA, ST_RB});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      m_q    <= 1'b0;
      xfer_q <= 1'b0;
      gain_q <= 1'b0;
      loss_q <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      m_q    <= m_d;
      xfer_q <= xfer_d;
      gain_q <= m_d & ~m_q;
      loss_q <= ~m_d & m_q;
      srst_q <= srst_d;
    end
  end

  // SDA stays pulled in ST_MST until the data stage takes over the line
  assign sda_pull_n = !(st_q inside {ST_SHOLD, ST_MST, ST_PA, ST_PB});
  assign scl_pull_n = !(st_q inside {ST_MST, ST_PA, ST_RA});
  assign is_master  = m_q;
  assign mst_gain   = gain_q;
  assign mst_loss   = loss_q;
  assign slave_rst  = srst_q;
endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl #(
  parameter int HALF        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sw_wr,
  input  logic sw_sta,
  input  logic sw_sto,
  input  logic byte_done,
  input  logic sda_i,
  input  logic scl_i,
  output logic sda_pull_n,
  output logic scl_pull_n,
  output logic sta_bit,
  output logic sto_bit,
  output logic is_master,
  output logic bus_busy,
  output logic mst_gain,
  output logic mst_loss,
  output logic slave_rst
);
  logic sta_q, sta_d, sto_q, sto_d;
  logic sta_clr, sto_clr, force_free, stop_det, tmr_load, tmr_done;

  // a software write takes precedence over a hardware clear in the same cycle
  always_comb begin
    sta_d = sw_wr ? sw_sta : (sta_clr ? 1'b0 : sta_q);
    sto_d = sw_wr ? sw_sto : (sto_clr ? 1'b0 : sto_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q <= 1'b0;
      sto_q <= 1'b0;
    end else begin
      sta_q <= sta_d;
      sto_q <= sto_d;
    end
  end

  i2c_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_i), .scl_i(scl_i),
    .force_free(force_free), .stop_det(stop_det), .bus_busy(bus_busy)
  );

  i2c_half_timer #(.HALF(HALF)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .done(tmr_done)
  );

  i2c_cond_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .sta(sta_q), .sto(sto_q),
    .bus_busy(bus_busy), .stop_det(stop_det), .byte_done(byte_done),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .sta_clr(sta_clr),
    .sto_clr(sto_clr), .force_free(force_free), .sda_pull_n(sda_pull_n),
    .scl_pull_n(scl_pull_n), .is_master(is_master), .mst_gain(mst_gain),
    .mst_loss(mst_loss), .slave_rst(slave_rst)
  );

  assign sta_bit = sta_q;
  assign sto_bit = sto_q;
endmodule

// File: rtl/i2c_cond_chk.sv
module i2c_cond_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic sda_pull_n,
  input logic scl_pull_n,
  input logic is_master,
  input logic bus_busy,
  input logic mst_gain,
  input logic mst_loss,
  input logic slave_rst
);
  AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sda_pull_n && scl_pull_n && !is_master)); // R1

  AST_GAIN_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    mst_gain |-> (is_master && !$past(is_master))); // R2

  AST_START_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_pull_n) && scl_pull_n && !is_master) |-> !$past(bus_busy)); // R3

  AST_LOSS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    mst_loss |-> (!is_master && $past(is_master))); // R6

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    slave_rst |-> (!is_master && scl_pull_n)); // R7
endmodule

bind i2c_cond_ctrl i2c_cond_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sda_pull_n(sda_pull_n),
  .scl_pull_n(scl_pull_n), .is_master(is_master), .bus_busy(bus_busy),
  .mst_gain(mst_gain), .mst_loss(mst_loss), .slave_rst(slave_rst)
);

// File: tb/sim_i2c_cond_ctrl.sv
module sim_i2c_cond_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n, en, sw_wr, sw_sta, sw_sto, byte_done, tb_sda, tb_scl;
  logic sda_pull_n, scl_pull_n, sta_bit, sto_bit, is_master, bus_busy;
  logic mst_gain, mst_loss, slave_rst;
  wire sda_line = sda_pull_n & tb_sda;
  wire scl_line = scl_pull_n & tb_scl;

  int n_run = 0, n_fail = 0;
  int n_start = 0, n_stop = 0, n_gain = 0, n_loss = 0, n_srst = 0, n_pull = 0;
  logic p_sda = 1'b1, p_scl = 1'b1, finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cond_ctrl #(.HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .sw_wr(sw_wr), .sw_sta(sw_sta),
    .sw_sto(sw_sto), .byte_done(byte_done), .sda_i(sda_line), .scl_i(scl_line),
    .sda_pull_n(sda_pull_n), .scl_pull_n(scl_pull_n), .sta_bit(sta_bit),
    .sto_bit(sto_bit), .is_master(is_master), .bus_busy(bus_busy),
    .mst_gain(mst_gain), .mst_loss(mst_loss), .slave_rst(slave_rst)
  );

  // line and pulse observer, sampled on the falling edge
  always @(negedge clk) begin
    if (p_scl && scl_line && p_sda && !sda_line) n_start++;
    if (p_scl && scl_line && !p_sda && sda_line) n_stop++;
    if (mst_gain) n_gain++;
    if (mst_loss) n_loss++;
    if (slave_rst) n_srst++;
    if (!sda_pull_n || !scl_pull_n) n_pull++;
    p_sda = sda_line;
    p_scl = scl_line;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic en_v);
    @(negedge clk);
    rst_n = 1'b0; en = en_v; sw_wr = 0; sw_sta = 0; sw_sto = 0;
    byte_done = 0; tb_sda = 1; tb_scl = 1;
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic wr(input logic s_a, input logic s_o);
    sw_wr = 1; sw_sta = s_a; sw_sto = s_o;
    @(negedge clk);
    sw_wr = 0; sw_sta = 0; sw_sto = 0;
  endtask

  task automatic become_master();
    wr(1, 0);
    for (int i = 0; i < 100 && !is_master; i++) @(negedge clk);
  endtask

  // {en, busy, sta, sto, exp_pull, exp_srst, exp_busy, exp_sta, exp_sto}
  localparam int NV = 7;
  localparam logic [8:0] VEC [NV] = '{
    9'b0_0_1_0_0_0_0_1_0,  // R1 STA ignored when disabled
    9'b0_0_0_1_0_0_0_0_1,  // R1 STO ignored when disabled
    9'b1_0_1_0_1_0_1_0_0,  // R2 START on free bus
    9'b1_0_0_0_0_0_0_0_0,  // R2 no request, nothing happens
    9'b1_1_1_0_0_0_1_1_0,  // R3 START deferred while busy
    9'b1_1_0_1_0_1_0_0_0,  // R7 slave recovery frees bus silently
    9'b0_1_0_1_0_0_1_0_1   // R1 recovery not taken when disabled
  };
  localparam int VREQ [NV] = '{1, 1, 2, 2, 3, 7, 1};

  initial begin
    int n, s0, s1, g0, l0, p0;
    do_reset(1'b0);
    // R10 reset state, checked while reset is held
    @(negedge clk); rst_n = 1'b0; cyc(1);
    check(sda_pull_n && scl_pull_n && !is_master && !bus_busy && !sta_bit && !sto_bit,
          "R10 reset state", {sda_pull_n, scl_pull_n, is_master, bus_busy, sta_bit, sto_bit}, 6'b110000);
    rst_n = 1'b1; cyc(2);

    for (int v = 0; v < NV; v++) begin
      logic [8:0] e;
      e = VEC[v];
      do_reset(e[8]);
      if (e[7]) begin tb_sda = 0; cyc(5); end
      p0 = n_pull; s0 = n_srst;
      wr(e[6], e[5]);
      cyc(40);
      check((n_pull != p0) == e[4], $sformatf("R%0d vec%0d pull", VREQ[v], v), n_pull - p0, e[4]);
      check((n_srst - s0) == int'(e[3]), $sformatf("R%0d vec%0d slave_rst", VREQ[v], v), n_srst - s0, e[3]);
      check({bus_busy, sta_bit, sto_bit} == e[2:0], $sformatf("R%0d vec%0d busy/sta/sto", VREQ[v], v),
            {bus_busy, sta_bit, sto_bit}, e[2:0]);
    end

    // R9 bus monitor
    do_reset(1'b0);
    tb_sda = 0; cyc(5);
    check(bus_busy == 1, "R9 busy on START", bus_busy, 1);
    tb_sda = 1; cyc(5);
    check(bus_busy == 0, "R9 free on STOP", bus_busy, 0);
    tb_scl = 0; cyc(2); tb_sda = 0; cyc(4); tb_sda = 1; cyc(4); tb_scl = 1; cyc(4);
    check(bus_busy == 0, "R9 SDA moves with SCL low", bus_busy, 0);

    // R2 R4 START timing
    do_reset(1'b1);
    g0 = n_gain;
    wr(1, 0);
    for (int i = 0; i < 20 && sda_pull_n; i++) @(negedge clk);
    check(!sda_pull_n && scl_pull_n, "R2 SDA pulled with SCL released", {sda_pull_n, scl_pull_n}, 2'b01);
    n = 0;
    for (int i = 0; i < 40 && scl_pull_n; i++) begin @(negedge clk); n++; end
    check(n == HALF, "R4 START hold length", n, HALF);
    cyc(1);
    check(is_master && !sta_bit && (n_gain - g0) == 1, "R2 mastership taken",
          {is_master, sta_bit, 1'(n_gain - g0)}, 3'b101);

    // R5 repeated START
    s0 = n_start; g0 = n_gain;
    wr(1, 0); cyc(30);
    check(n_start == s0 && sta_bit, "R5 no repeated START without byte", n_start - s0, 0);
    byte_done = 1; @(negedge clk); byte_done = 0;
    for (int i = 0; i < 100 && n_start == s0; i++) @(negedge clk);
    cyc(HALF + 4);
    check(n_start - s0 == 1 && is_master && n_gain == g0 && !sta_bit, "R5 repeated START",
          n_start - s0, 1);

    // R6 STOP as master
    s1 = n_stop; l0 = n_loss;
    wr(0, 1);
    for (int i = 0; i < 60 && !scl_pull_n; i++) @(negedge clk);
    n = 0;
    for (int i = 0; i < 40 && !sda_pull_n; i++) begin @(negedge clk); n++; end
    check(n == HALF, "R6 SCL-to-SDA release gap", n, HALF);
    cyc(6);
    check(n_stop - s1 == 1, "R6 STOP seen on bus", n_stop - s1, 1);
    check(!is_master && !sto_bit && n_loss - l0 == 1 && sda_pull_n && scl_pull_n,
          "R6 mastership dropped", {is_master, sto_bit, 1'(n_loss - l0)}, 3'b001);

    // R8 STOP then START
    do_reset(1'b1);
    become_master(); cyc(3);
    s0 = n_start; s1 = n_stop;
    wr(1, 1);
    cyc(6 * HALF + 20);
    check(n_stop - s1 == 1 && n_start - s0 == 1, "R8 stop count", n_stop - s1, 1);
    check(is_master && !sta_bit && !sto_bit, "R8 master after restart",
          {is_master, sta_bit, sto_bit}, 3'b100);

    // R11 enable dropped while master
    l0 = n_loss;
    en = 0; cyc(2);
    check(sda_pull_n && scl_pull_n && !is_master && n_loss - l0 == 1, "R11 abort on disable",
          {sda_pull_n, scl_pull_n, is_master}, 3'b110);

    // R3 deferred START timing after another master's STOP
    do_reset(1'b1);
    tb_sda = 0; cyc(5);
    wr(1, 0); cyc(30);
    check(sda_pull_n && scl_pull_n, "R3 held off while busy", {sda_pull_n, scl_pull_n}, 2'b11);
    tb_sda = 1;
    n = 0;
    for (int i = 0; i < 60 && sda_pull_n; i++) begin @(negedge clk); n++; end
    check(n >= HALF + 2 && n <= HALF + 4, "R3 half-period gap", n, HALF + 3);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule